// File: doc/BRIEF.md
# Copy Command Stream Generator

This block turns one two-dimensional copy descriptor into the sequence of 32-bit command words that a copy engine consumes. The descriptor gives the memory layout of each side (linear, X-tiled, Y-tiled or 4-tiled), the copy width and height, the 64-bit source and destination addresses, and two options. The first option picks the fast copy format; the second enables 64-bit addressing for the older format. The block sends one word per accepted cycle on a valid/ready stream and marks the final word.

With the fast format the stream is a three-word register load that sets cache control, then a ten-word fast copy packet, then a terminator. With the older format the stream is a three-word register load that selects Y tiling per side, then a four-word flush, then a copy packet of eight or ten words, then the terminator. In both formats the pitch of each side depends on its layout.

Top module: `blit_emit`

## Requirements
- R1: During and directly after reset, cmd_valid is 0 and req_ready is 1.
- R2: A descriptor is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from that edge until the edge that transfers the terminator, and descriptor inputs seen while busy do not change the stream.
- R3: With req_fast=1 the stream is 14 words: 0x22000001, the cache register offset (parameter CACHE_REG), the cache value (parameter CACHE_VAL), the fast packet (words 3..12), then the terminator.
- R4: Fast packet word 0 is 0x50400008 OR source mode at bits [21:20] OR destination mode at bits [14:13], with mode 0 for linear, 1 for X and 2 for both Y and 4-tile.
- R5: Fast packet word 1 has bit 31 set for a 4-tiled source, bit 30 set for a 4-tiled destination, 2'b11 (32-bit depth) at bits [25:24] and the destination pitch in bits [15:0]; word 2 is 0.
- R6: A side's pitch is width*4 (bytes, kept to 16 bits) when linear and width (dwords) when tiled, in both formats; source pitch is fast packet word 7 and older packet word 7 (wide) or 6 (narrow).
- R7: The word after the zero word holds height in [31:16] and width in [15:0]; then destination address low and high, a zero word, the source pitch, source address low and high.
- R8: With req_fast=0 the stream starts with 0x22000001, the tiling control register offset (parameter TILE_REG), then 0x00030000 with bit 0 set only for a Y-tiled source and bit 1 only for a Y-tiled destination.
- R9: The older format then gives a flush word 0x13000002, or 0x13000003 when req_wide=1, followed by three zero words.
- R10: The older copy packet word 0 is 0x54C00006, plus 2 when req_wide=1, with bit 15 set for a non-linear source and bit 11 for a non-linear destination; word 1 is 0x03CC0000 OR the destination pitch; with req_wide=0 the two high address words are left out (16-word stream), with req_wide=1 they are present (18 words).
- R11: Every stream ends with 0x05000000, cmd_last is 1 on that word only, and cmd_valid is 0 on the cycle after it is transferred.
- R12: While cmd_valid=1 and cmd_ready=0, cmd_valid, cmd_data and cmd_last hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Block idle, descriptor can be taken |
| req_fast | input | 1 | 1 selects the fast copy format |
| req_wide | input | 1 | 1 enables 64-bit addressing in the older format |
| req_src_lay | input | 2 | Source layout: 0 linear, 1 X, 2 Y, 3 4-tile |
| req_dst_lay | input | 2 | Destination layout, same encoding |
| req_width | input | DIM_W | Copy width in pixels |
| req_height | input | DIM_W | Copy height in rows |
| req_src_addr | input | ADDR_W | Source base address |
| req_dst_addr | input | ADDR_W | Destination base address |
| cmd_valid | output | 1 | Command word present |
| cmd_ready | input | 1 | Consumer takes the word |
| cmd_data | output | 32 | Command word |
| cmd_last | output | 1 | Marks the terminator word |

## Verification
The first command word is visible directly after the clock edge that takes the descriptor, each further word after an edge where cmd_ready was 1, and the block is idle again one edge after the terminator is taken. The bench drives inputs and samples outputs on the falling edge, recording a word as transferred only when cmd_valid and cmd_ready were both 1 at that falling edge, so each comparison is made in the cycle the word is due. Under stall patterns the bench compares the held word on the following falling edge, and it offers a different descriptor while busy and confirms the stream it receives matches the first one.

// File: rtl/blit_pkg.sv
package blit_pkg;

   typedef enum logic [1:0] {
      LAY_LINEAR = 2'd0,
      LAY_X      = 2'd1,
      LAY_Y      = 2'd2,
      LAY_T4     = 2'd3
   } layout_e;

   // tile mode codes placed in the fast packet header
   localparam logic [1:0] TM_LINEAR = 2'd0;
   localparam logic [1:0] TM_X      = 2'd1;
   localparam logic [1:0] TM_YMAJ   = 2'd2;

   localparam logic [31:0] OP_LOAD_REG = 32'h2200_0001;
   localparam logic [31:0] OP_FLUSH    = 32'h1300_0002;
   localparam logic [31:0] OP_FAST     = 32'h5040_0008;
   localparam logic [31:0] OP_COPY     = 32'h54C0_0006;
   localparam logic [31:0] OP_END      = 32'h0500_0000;

   localparam logic [1:0]  DEPTH_32    = 2'b11;
   localparam logic [7:0]  ROP_COPY    = 8'hCC;
   localparam logic [15:0] YSEL_MASK   = 16'h0003;

   localparam int FAST_SRC_TM_LSB = 20;
   localparam int FAST_DST_TM_LSB = 13;
   localparam int COPY_SRC_T_BIT  = 15;
   localparam int COPY_DST_T_BIT  = 11;

   localparam int LEN_W        = 5;
   localparam int LEN_FAST     = 14;
   localparam int LEN_NARROW   = 16;
   localparam int LEN_WIDE     = 18;
   localparam int LEG_PKT_BASE = 7;

endpackage

// File: rtl/blit_side_decode.sv
module blit_side_decode
   import blit_pkg::*;
#(
   parameter int DIM_W = 16
) (
   input  logic [1:0]       lay,
   input  logic [DIM_W-1:0] width,
   output logic [1:0]       tile_mode,
   output logic             four_tile,
   output logic             tiled,
   output logic             y_sel,
   output logic [15:0]      pitch
);
   localparam int WB_W = DIM_W + 2;

   logic [WB_W-1:0] bytes_w;

   assign bytes_w   = {width, 2'b00};
   assign tiled     = (lay != LAY_LINEAR);
   assign four_tile = (lay == LAY_T4);
   assign y_sel     = (lay == LAY_Y);
   assign pitch     = tiled ? 16'(width) : bytes_w[15:0];

   always_comb begin
      unique case (lay)
         LAY_LINEAR: tile_mode = TM_LINEAR;
         LAY_X:      tile_mode = TM_X;
         default:    tile_mode = TM_YMAJ;
      endcase
   end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
   import blit_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len_in,
   input  logic             out_ready,
   output logic             busy,
   output logic [LEN_W-1:0] idx,
   output logic             last
);
   logic [LEN_W-1:0] len_q;

   assign last = busy && (idx == len_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         len_q <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            idx   <= '0;
            len_q <= len_in;
         end
      end else if (out_ready) begin
         if (last) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R12: the position does not move while the consumer stalls
   p_idx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !out_ready |=> busy && $stable(idx));

   // R11: the terminator transfer returns the block to idle
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy && out_ready && last |=> !busy);

   // R3: the position never runs past the chosen length
   p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> idx < len_q);
endmodule

// File: rtl/blit_word_sel.sv
module blit_word_sel
   import blit_pkg::*;
#(
   parameter logic [31:0] CACHE_REG = 32'h0002_2200,
   parameter logic [31:0] CACHE_VAL = 32'h0000_0606,
   parameter logic [31:0] TILE_REG  = 32'h0002_2280
) (
   input  logic             fast,
   input  logic             wide,
   input  logic [LEN_W-1:0] idx,
   input  logic [1:0]       src_tm,
   input  logic [1:0]       dst_tm,
   input  logic             src_t4,
   input  logic             dst_t4,
   input  logic             src_tiled,
   input  logic             dst_tiled,
   input  logic             src_y,
   input  logic             dst_y,
   input  logic [15:0]      src_pitch,
   input  logic [15:0]      dst_pitch,
   input  logic [31:0]      size_word,
   input  logic [31:0]      src_lo,
   input  logic [31:0]      src_hi,
   input  logic [31:0]      dst_lo,
   input  logic [31:0]      dst_hi,
   output logic [31:0]      word
);
   logic [LEN_W-1:0] pkt_pos;
   logic [LEN_W-1:0] slot;
   logic [LEN_W-1:0] pkt_len;

   assign pkt_pos = idx - LEN_W'(LEG_PKT_BASE);
   assign pkt_len = wide ? LEN_W'(10) : LEN_W'(8);
   // narrow packets skip the two high-address slots
   assign slot    = (wide || pkt_pos < LEN_W'(5)) ? pkt_pos : pkt_pos + 1'b1;

   always_comb begin
      word = '0;
      if (fast) begin
         case (idx)
            5'd0:  word = OP_LOAD_REG;
            5'd1:  word = CACHE_REG;
            5'd2:  word = CACHE_VAL;
            5'd3:  word = OP_FAST | (32'(src_tm) << FAST_SRC_TM_LSB)
                                  | (32'(dst_tm) << FAST_DST_TM_LSB);
            5'd4:  word = {src_t4, dst_t4, 4'b0000, DEPTH_32, 8'h00, dst_pitch};
            5'd6:  word = size_word;
            5'd7:  word = dst_lo;
            5'd8:  word = dst_hi;
            5'd10: word = {16'h0000, src_pitch};
            5'd11: word = src_lo;
            5'd12: word = src_hi;
            5'd13: word = OP_END;
            default: word = '0;
         endcase
      end else if (idx < LEN_W'(LEG_PKT_BASE)) begin
         case (idx)
            5'd0:    word = OP_LOAD_REG;
            5'd1:    word = TILE_REG;
            5'd2:    word = {YSEL_MASK, 14'h0000, dst_y, src_y};
            5'd3:    word = OP_FLUSH + {31'd0, wide};
            default: word = '0;
         endcase
      end else if (pkt_pos >= pkt_len) begin
         word = OP_END;
      end else begin
         case (slot)
            5'd0: word = (OP_COPY + (wide ? 32'd2 : 32'd0))
                         | (32'(src_tiled) << COPY_SRC_T_BIT)
                         | (32'(dst_tiled) << COPY_DST_T_BIT);
            5'd1: word = {6'b000000, DEPTH_32, ROP_COPY, dst_pitch};
            5'd3: word = size_word;
            5'd4: word = dst_lo;
            5'd5: word = dst_hi;
            5'd7: word = {16'h0000, src_pitch};
            5'd8: word = src_lo;
            5'd9: word = src_hi;
            default: word = '0;
         endcase
      end
   end
endmodule

// File: rtl/blit_emit.sv
module blit_emit
   import blit_pkg::*;
#(
   parameter int          DIM_W     = 16,
   parameter int          ADDR_W    = 64,
   parameter logic [31:0] CACHE_REG = 32'h0002_2200,
   parameter logic [31:0] CACHE_VAL = 32'h0000_0606,
   parameter logic [31:0] TILE_REG  = 32'h0002_2280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_fast,
   input  logic              req_wide,
   input  logic [1:0]        req_src_lay,
   input  logic [1:0]        req_dst_lay,
   input  logic [DIM_W-1:0]  req_width,
   input  logic [DIM_W-1:0]  req_height,
   input  logic [ADDR_W-1:0] req_src_addr,
   input  logic [ADDR_W-1:0] req_dst_addr,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [31:0]       cmd_data,
   output logic              cmd_last
);
   localparam int NSIDE = 2;   // index 0 source, 1 destination

   initial begin
      assert (DIM_W >= 2 && DIM_W <= 16)
         else $error("blit_emit: DIM_W must lie in 2..16");
      assert (ADDR_W > 32 && ADDR_W <= 64)
         else $error("blit_emit: ADDR_W must lie in 33..64");
   end

   logic              busy, start, last;
   logic [LEN_W-1:0]  idx, len_in;
   logic              fast_q, wide_q;
   logic [1:0]        lay_q  [NSIDE];
   logic [ADDR_W-1:0] addr_q [NSIDE];
   logic [DIM_W-1:0]  width_q, height_q;

   logic [1:0]  side_tm    [NSIDE];
   logic        side_t4    [NSIDE];
   logic        side_tiled [NSIDE];
   logic        side_y     [NSIDE];
   logic [15:0] side_pitch [NSIDE];
   logic [31:0] side_lo    [NSIDE];
   logic [31:0] side_hi    [NSIDE];

   assign req_ready = !busy;
   assign start     = req_valid && !busy;
   assign len_in    = req_fast ? LEN_W'(LEN_FAST)
                    : (req_wide ? LEN_W'(LEN_WIDE) : LEN_W'(LEN_NARROW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_q    <= 1'b0;
         wide_q    <= 1'b0;
         lay_q[0]  <= '0;
         lay_q[1]  <= '0;
         addr_q[0] <= '0;
         addr_q[1] <= '0;
         width_q   <= '0;
         height_q  <= '0;
      end else if (start) begin
         fast_q    <= req_fast;
         wide_q    <= req_wide;
         lay_q[0]  <= req_src_lay;
         lay_q[1]  <= req_dst_lay;
         addr_q[0] <= req_src_addr;
         addr_q[1] <= req_dst_addr;
         width_q   <= req_width;
         height_q  <= req_height;
      end
   end

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      blit_side_decode #(.DIM_W(DIM_W)) u_dec (
         .lay       (lay_q[s]),
         .width     (width_q),
         .tile_mode (side_tm[s]),
         .four_tile (side_t4[s]),
         .tiled     (side_tiled[s]),
         .y_sel     (side_y[s]),
         .pitch     (side_pitch[s])
      );
      assign side_lo[s] = addr_q[s][31:0];
      if (ADDR_W == 64) begin : g_full
         assign side_hi[s] = addr_q[s][63:32];
      end else begin : g_part
         assign side_hi[s] = {{(64-ADDR_W){1'b0}}, addr_q[s][ADDR_W-1:32]};
      end
   end

   blit_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .len_in    (len_in),
      .out_ready (cmd_ready),
      .busy      (busy),
      .idx       (idx),
      .last      (last)
   );

   blit_word_sel #(
      .CACHE_REG (CACHE_REG),
      .CACHE_VAL (CACHE_VAL),
      .TILE_REG  (TILE_REG)
   ) u_sel (
      .fast      (fast_q),
      .wide      (wide_q),
      .idx       (idx),
      .src_tm    (side_tm[0]),
      .dst_tm    (side_tm[1]),
      .src_t4    (side_t4[0]),
      .dst_t4    (side_t4[1]),
      .src_tiled (side_tiled[0]),
      .dst_tiled (side_tiled[1]),
      .src_y     (side_y[0]),
      .dst_y     (side_y[1]),
      .src_pitch (side_pitch[0]),
      .dst_pitch (side_pitch[1]),
      .size_word ({16'(height_q), 16'(width_q)}),
      .src_lo    (side_lo[0]),
      .src_hi    (side_hi[0]),
      .dst_lo    (side_lo[1]),
      .dst_hi    (side_hi[1]),
      .word      (cmd_data)
   );

   assign cmd_valid = busy;
   assign cmd_last  = last;

   // R12: a stalled word and its marker stay put
   p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data) && $stable(cmd_last));

   // R11: the marked word is always the terminator
   p_end_on_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_last |-> cmd_data == OP_END);

   // R2: no descriptor is offered a slot while a stream is out
   p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !req_ready);

   // R3 / R8: both formats open with a register load
   p_open_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> cmd_data == OP_LOAD_REG);
endmodule

// File: tb/tb_blit_emit.sv
module tb_blit_emit;
   localparam logic [31:0] CACHE_REG = 32'h0002_2200;
   localparam logic [31:0] CACHE_VAL = 32'h0000_0606;
   localparam logic [31:0] TILE_REG  = 32'h0002_2280;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_fast = 1'b0, req_wide = 1'b0;
   logic [1:0]  req_src_lay = '0, req_dst_lay = '0;
   logic [15:0] req_width = '0, req_height = '0;
   logic [63:0] req_src_addr = '0, req_dst_addr = '0;
   logic        cmd_valid, cmd_ready = 1'b0, cmd_last;
   logic [31:0] cmd_data;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   logic [31:0] exp_w [18];
   string       exp_t [18];
   int          exp_n;

   always #4 clk = ~clk;

   blit_emit #(.DIM_W(16), .ADDR_W(64), .CACHE_REG(CACHE_REG),
               .CACHE_VAL(CACHE_VAL), .TILE_REG(TILE_REG)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_fast(req_fast), .req_wide(req_wide), .req_src_lay(req_src_lay),
      .req_dst_lay(req_dst_lay), .req_width(req_width), .req_height(req_height),
      .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
      .cmd_last(cmd_last));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic [1:0] mode_of(input logic [1:0] l);
      return (l == 2'd0) ? 2'd0 : (l == 2'd1) ? 2'd1 : 2'd2;
   endfunction

   function automatic logic [15:0] pitch_of(input logic [1:0] l, input logic [15:0] w);
      logic [17:0] b = {w, 2'b00};
      return (l == 2'd0) ? b[15:0] : w;
   endfunction

   task automatic put(input logic [31:0] w, input string t);
      exp_w[exp_n] = w;
      exp_t[exp_n] = t;
      exp_n++;
   endtask

   task automatic build_exp(input bit fast, input bit wide, input logic [1:0] sl,
                            input logic [1:0] dl, input logic [15:0] w,
                            input logic [15:0] h, input logic [63:0] sa,
                            input logic [63:0] da);
      logic [15:0] sp = pitch_of(sl, w);
      logic [15:0] dp = pitch_of(dl, w);
      exp_n = 0;
      if (fast) begin
         put(32'h2200_0001, "R3"); put(CACHE_REG, "R3"); put(CACHE_VAL, "R3");
         put(32'h5040_0008 | (32'(mode_of(sl)) << 20) | (32'(mode_of(dl)) << 13), "R4");
         put((32'(sl == 2'd3) << 31) | (32'(dl == 2'd3) << 30) | (32'd3 << 24) | 32'(dp), "R5");
         put(32'h0, "R5");
         put({h, w}, "R7"); put(da[31:0], "R7"); put(da[63:32], "R7");
         put(32'h0, "R7"); put(32'(sp), "R6"); put(sa[31:0], "R7"); put(sa[63:32], "R7");
      end else begin
         put(32'h2200_0001, "R8"); put(TILE_REG, "R8");
         put(32'h0003_0000 | (dl == 2'd2 ? 32'd2 : 32'd0) | (sl == 2'd2 ? 32'd1 : 32'd0), "R8");
         put(wide ? 32'h1300_0003 : 32'h1300_0002, "R9");
         put(32'h0, "R9"); put(32'h0, "R9"); put(32'h0, "R9");
         put((32'h54C0_0006 + (wide ? 32'd2 : 32'd0)) | (32'(sl != 2'd0) << 15)
             | (32'(dl != 2'd0) << 11), "R10");
         put(32'h03CC_0000 | 32'(dp), "R6");
         put(32'h0, "R10"); put({h, w}, "R7"); put(da[31:0], "R7");
         if (wide) put(da[63:32], "R10");
         put(32'h0, "R7"); put(32'(sp), "R6"); put(sa[31:0], "R7");
         if (wide) put(sa[63:32], "R10");
      end
      put(32'h0500_0000, "R11");
   endtask

   function automatic bit ready_at(input int mode, input int cyc);
      case (mode)
         1:       return (cyc % 2) == 1;
         2:       return (cyc % 3) == 2;
         default: return 1'b1;
      endcase
   endfunction

   // drive one descriptor, drain its stream and compare word by word
   task automatic run_stream(input bit fast, input bit wide, input logic [1:0] sl,
                             input logic [1:0] dl, input logic [15:0] w,
                             input logic [15:0] h, input logic [63:0] sa,
                             input logic [63:0] da, input int stall, input bit poke);
      int cnt = 0;
      bit done = 1'b0, held = 1'b0;
      logic [31:0] held_d = '0;
      logic held_l = 1'b0;
      build_exp(fast, wide, sl, dl, w, h, sa, da);
      req_fast = fast; req_wide = wide; req_src_lay = sl; req_dst_lay = dl;
      req_width = w; req_height = h; req_src_addr = sa; req_dst_addr = da;
      req_valid = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R2 ready low while busy", 32'(req_ready), 32'd0);
      if (poke) begin
         // R2: a second offer while busy must leave the stream untouched
         req_fast = ~fast; req_wide = ~wide; req_src_lay = ~sl; req_dst_lay = ~dl;
         req_width = w + 16'd3; req_height = h + 16'd9;
         req_src_addr = ~sa; req_dst_addr = ~da;
      end else begin
         req_valid = 1'b0;
      end
      for (int cyc = 0; cyc < 400 && !done; cyc++) begin
         bit r = ready_at(stall, cyc);
         if (held) begin
            chk(cmd_valid && cmd_data == held_d && cmd_last == held_l,
                "R12 held word", cmd_data, held_d);
         end
         cmd_ready = r;
         if (cmd_valid && r) begin
            held = 1'b0;
            if (cnt < exp_n) begin
               chk(cmd_data == exp_w[cnt], exp_t[cnt], cmd_data, exp_w[cnt]);
               chk(cmd_last == (cnt == exp_n - 1), "R11 last marker",
                   32'(cmd_last), 32'(cnt == exp_n - 1));
            end
            cnt++;
            if (cmd_last) begin
               done = 1'b1;
               req_valid = 1'b0;
            end
         end else if (cmd_valid) begin
            held = 1'b1;
            held_d = cmd_data;
            held_l = cmd_last;
         end
         if (!done) @(negedge clk);
      end
      chk(cnt == exp_n, fast ? "R3 stream length" : "R10 stream length",
          32'(cnt), 32'(exp_n));
      @(negedge clk);
      cmd_ready = 1'b0;
      chk(!cmd_valid && req_ready, "R11 idle after terminator",
          {30'd0, cmd_valid, req_ready}, 32'd1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R1 valid in reset", 32'(cmd_valid), 32'd0);
      chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cmd_valid && req_ready, "R1 idle after reset",
          {30'd0, cmd_valid, req_ready}, 32'd1);
   endtask

   task automatic t_fast_layouts();
      for (int s = 0; s < 4; s++)
         for (int d = 0; d < 4; d++)
            run_stream(1'b1, 1'b0, 2'(s), 2'(d), 16'd512, 16'd32,
                       64'h0000_0012_3456_7000 + 64'(s),
                       64'h0000_00AB_CDE0_1000 + 64'(d), 0, 1'b0);
   endtask

   task automatic t_legacy_layouts();
      for (int s = 0; s < 4; s++)
         for (int d = 0; d < 4; d++)
            run_stream(1'b0, 1'((s + d) % 2), 2'(s), 2'(d), 16'd100 + 16'(s), 16'd7,
                       64'h8000_0001_0000_4000, 64'h0000_0003_FFFF_C000, 0, 1'b0);
   endtask

   task automatic t_backpressure();
      run_stream(1'b1, 1'b0, 2'd3, 2'd1, 16'd20, 16'd5,
                 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1, 1'b0);
      run_stream(1'b0, 1'b1, 2'd2, 2'd0, 16'h3FFF, 16'hFFFF,
                 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 2, 1'b0);
      run_stream(1'b0, 1'b0, 2'd0, 2'd2, 16'd1, 16'd1,
                 64'h0000_0000_0000_1000, 64'h0000_0000_0000_2000, 2, 1'b0);
   endtask

   task automatic t_busy_ignore();
      run_stream(1'b1, 1'b0, 2'd2, 2'd0, 16'd64, 16'd16,
                 64'h0000_0042_0000_0000, 64'h0000_0043_0000_0000, 1, 1'b1);
      run_stream(1'b0, 1'b0, 2'd1, 2'd3, 16'd9, 16'd4,
                 64'h0000_0001_2000_0000, 64'h0000_0002_4000_0000, 0, 1'b1);
   endtask

   initial begin
      t_reset();
      t_fast_layouts();
      t_legacy_layouts();
      t_backpressure();
      t_busy_ignore();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule